// File: doc/BRIEF.md
# Supervisor Reset and Watchdog with Fault Register

This block drives a chip's system reset. It combines three low-voltage comparator outputs, a manual reset request and a watchdog. A 2-bit configuration field sets the reset-release delay, and a second 2-bit field sets the watchdog period or turns the watchdog off. All times are counted in clock ticks: each nominal millisecond lasts `TICKS_PER_MS` cycles.

The block also keeps a volatile fault register that records what caused each reset. When reset is triggered, the block sets a flag for every source that is active at that moment. The flags hold until software overwrites the register. The serial front end reports each finished write as one commit pulse, together with the device-type preamble, the address, the data-byte count and the first data byte. The register accepts only a single-byte write that carries the fault preamble and the fault address. No write-enable step is needed.

Top module: `rst_supervisor`

## Requirements
- R1: After `rst_n` is released, `sys_rst` stays high for exactly N sampled cycles. N is `pup_code` 00/01/10/11 → 50/200/400/800 × `TICKS_PER_MS`.
- R2: While the block is running, any high bit of `lv_low` or a high `mr_req` sets `sys_rst` on the next clock edge. `sys_rst` stays high as long as any source is high.
- R3: Once all sources are low, `sys_rst` stays high for N cycles (the same codes as R1). A source that returns during the delay restarts the full delay.
- R4: The watchdog codes in `wd_code` are 00/01/10 → 1400/200/25 × `TICKS_PER_MS` cycles. Running for that many cycles with no kick sets `sys_rst`.
- R5: `wd_code` 11 disables the watchdog. No timeout occurs, however long `wd_kick` stays low.
- R6: Each `wd_kick` restarts the full watchdog period. The period also restarts every time reset is released.
- R7: The fault register layout is: bit7 = `lv_low[0]`, bit6 = `lv_low[1]`, bit5 = `lv_low[2]`, bit4 = watchdog timeout, bit3 = manual reset. Bits 2..0 always read 0. `rst_n` clears the register.
- R8: A trigger sets the flags of all sources active at the trigger edge, and a watchdog timeout sets bit4. Sources that appear while reset is already held set no flag. Flags hold until they are overwritten.
- R9: A write takes effect only if it has `wr_type` 4'b1011, `wr_addr` 8'hFF and `wr_nbytes` 1. Any other write has no effect.
- R10: An accepted write loads `wr_data` with bits 2..0 forced to 0. A trigger on the same edge ORs its flags onto the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| lv_low | input | 3 | Low-voltage comparator outputs, active high |
| mr_req | input | 1 | Manual reset request, active high |
| wd_kick | input | 1 | Watchdog service strobe |
| pup_code | input | 2 | Reset-release delay select |
| wd_code | input | 2 | Watchdog period select, 11 = off |
| wr_commit | input | 1 | One-cycle pulse when a write finishes |
| wr_type | input | 4 | Device-type preamble of the write |
| wr_addr | input | 8 | Register address of the write |
| wr_nbytes | input | 4 | Number of data bytes in the write |
| wr_data | input | 8 | First data byte |
| fdr_q | output | 8 | Fault register read value |
| sys_rst | output | 1 | System reset, active high |

## Verification
The hardest case to reach is a write that lands on the same edge as a trigger. The stimulus lines up a clearing write with a manual reset in a single negedge drive, so both are seen at one posedge. A second hard case is a source that reappears partway through the release delay. The bench pulses a comparator input for one cycle mid-delay and then measures the full delay again from the second release. Watchdog periods are measured twice: once from a kick, and once from the moment the reset caused by the timeout is released.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   typedef enum logic [1:0] {ST_HOLD, ST_DELAY, ST_RUN} sup_state_e;

   typedef enum logic {PK_RELEASE, PK_WATCHDOG} period_kind_e;

   localparam int MAX_RELEASE_MS = 800;
   localparam int MAX_WATCHDOG_MS = 1400;

   function automatic int release_ms(input logic [1:0] code);
      case (code)
         2'b00: return 50;
         2'b01: return 200;
         2'b10: return 400;
         default: return 800;
      endcase
   endfunction

   function automatic int watchdog_ms(input logic [1:0] code);
      case (code)
         2'b00: return 1400;
         2'b01: return 200;
         2'b10: return 25;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/rsup_period_sel.sv
module rsup_period_sel #(
   parameter rsup_pkg::period_kind_e KIND = rsup_pkg::PK_RELEASE,
   parameter int TICKS_PER_MS = 1000,
   parameter int W = 20
) (
   input  logic [1:0]   code,
   output logic [W-1:0] ticks,
   output logic         enabled
);

   initial assert (TICKS_PER_MS >= 1) else $error("TICKS_PER_MS must be at least 1");

   generate
      if (KIND == rsup_pkg::PK_RELEASE) begin : g_release
         always_comb begin
            ticks   = W'(rsup_pkg::release_ms(code) * TICKS_PER_MS);
            enabled = 1'b1;
         end
      end else begin : g_watchdog
         always_comb begin
            ticks   = W'(rsup_pkg::watchdog_ms(code) * TICKS_PER_MS);
            enabled = (code != 2'b11);
         end
      end
   endgenerate

endmodule

// File: rtl/rsup_ctrl.sv
module rsup_ctrl #(
   parameter int DCW = 16,
   parameter int WCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           src_any,
   input  logic           wd_kick,
   input  logic [DCW-1:0] dly_ticks,
   input  logic [WCW-1:0] wd_ticks,
   input  logic           wd_en,
   output logic           trig,
   output logic           wd_to,
   output logic           running
);
   import rsup_pkg::*;

   sup_state_e     state;
   logic [DCW-1:0] dly_cnt;
   logic [WCW-1:0] wd_cnt;

   assign running = (state == ST_RUN);
   assign wd_to   = running && wd_en && !wd_kick && (wd_cnt >= (wd_ticks - WCW'(1)));
   assign trig    = running && (src_any || wd_to);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_HOLD;
         dly_cnt <= '0;
      end else begin
         case (state)
            ST_HOLD: if (!src_any) begin
               state   <= ST_DELAY;
               dly_cnt <= dly_ticks - DCW'(1);
            end
            ST_DELAY: if (src_any) state <= ST_HOLD;
                      else if (dly_cnt == '0) state <= ST_RUN;
                      else dly_cnt <= dly_cnt - DCW'(1);
            default: if (src_any) state <= ST_HOLD;
                     else if (wd_to) begin
                        state   <= ST_DELAY;
                        dly_cnt <= dly_ticks - DCW'(1);
                     end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wd_cnt <= '0;
      else if (!running || wd_kick) wd_cnt <= '0;
      else if (!wd_to) wd_cnt <= wd_cnt + WCW'(1);
   end

   assert_delay_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DELAY && !src_any && dly_cnt != '0) |=> (dly_cnt == $past(dly_cnt) - DCW'(1)));

   assert_wd_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en |-> !wd_to);

   assert_kick_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && wd_kick) |=> (wd_cnt == '0));

endmodule

// File: rtl/rsup_fault_reg.sv
module rsup_fault_reg #(
   parameter logic [7:0] KEEP_MASK = 8'hF8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_en,
   input  logic [7:0] set_vec,
   input  logic       wr_ok,
   input  logic [7:0] wr_data,
   output logic [7:0] fdr_q
);

   logic [7:0] base;

   assign base = wr_ok ? wr_data : fdr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fdr_q <= '0;
      else        fdr_q <= (base | (set_en ? set_vec : 8'h00)) & KEEP_MASK;
   end

   assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ok && !set_en) |=> (fdr_q == $past(fdr_q)));

   assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (fdr_q[2:0] == 3'b000));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
   parameter int         TICKS_PER_MS = 1000,
   parameter logic [3:0] FDR_PREAMBLE = 4'b1011,
   parameter logic [7:0] FDR_ADDR     = 8'hFF,
   parameter int         NUM_LV       = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] lv_low,
   input  logic       mr_req,
   input  logic       wd_kick,
   input  logic [1:0] pup_code,
   input  logic [1:0] wd_code,
   input  logic       wr_commit,
   input  logic [3:0] wr_type,
   input  logic [7:0] wr_addr,
   input  logic [3:0] wr_nbytes,
   input  logic [7:0] wr_data,
   output logic [7:0] fdr_q,
   output logic       sys_rst
);

   localparam int DCW = $clog2(rsup_pkg::MAX_RELEASE_MS * TICKS_PER_MS + 1);
   localparam int WCW = $clog2(rsup_pkg::MAX_WATCHDOG_MS * TICKS_PER_MS + 1);
   localparam int LV_TOP = 7;
   localparam int WDF_BIT = 4;
   localparam int MRF_BIT = 3;

   initial assert (NUM_LV == 3) else $error("fault layout holds exactly three voltage flags");

   logic [DCW-1:0] dly_ticks;
   logic [WCW-1:0] wd_ticks;
   logic           dly_en_unused;
   logic           wd_en;
   logic           trig;
   logic           wd_to;
   logic           running;
   logic           src_any;
   logic           wr_ok;
   logic [7:0]     set_vec;

   assign src_any = (|lv_low) | mr_req;
   assign wr_ok   = wr_commit && (wr_type == FDR_PREAMBLE) && (wr_addr == FDR_ADDR)
                    && (wr_nbytes == 4'd1);

   generate
      for (genvar i = 0; i < NUM_LV; i++) begin : g_lv_flag
         assign set_vec[LV_TOP - i] = lv_low[i];
      end
   endgenerate
   assign set_vec[WDF_BIT]  = wd_to;
   assign set_vec[MRF_BIT]  = mr_req;
   assign set_vec[2:0]      = 3'b000;

   rsup_period_sel #(.KIND(rsup_pkg::PK_RELEASE), .TICKS_PER_MS(TICKS_PER_MS), .W(DCW)) u_dly_sel (
      .code(pup_code), .ticks(dly_ticks), .enabled(dly_en_unused));

   rsup_period_sel #(.KIND(rsup_pkg::PK_WATCHDOG), .TICKS_PER_MS(TICKS_PER_MS), .W(WCW)) u_wd_sel (
      .code(wd_code), .ticks(wd_ticks), .enabled(wd_en));

   rsup_ctrl #(.DCW(DCW), .WCW(WCW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .src_any(src_any), .wd_kick(wd_kick),
      .dly_ticks(dly_ticks), .wd_ticks(wd_ticks), .wd_en(wd_en),
      .trig(trig), .wd_to(wd_to), .running(running));

   rsup_fault_reg #(.KEEP_MASK(8'hF8)) u_fdr (
      .clk(clk), .rst_n(rst_n), .set_en(trig), .set_vec(set_vec),
      .wr_ok(wr_ok), .wr_data(wr_data), .fdr_q(fdr_q));

   assign sys_rst = !running;

   assert_src_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src_any |=> sys_rst);

   assert_reject_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && !wr_ok && !trig) |=> (fdr_q == $past(fdr_q)));

   assert_late_source_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst && !wr_ok) |=> ((fdr_q & ~$past(fdr_q)) == 8'h00));

endmodule

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;

   localparam int TPM = 2;
   localparam int LIMIT = 4000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] lv_low = '0;
   logic       mr_req = 1'b0;
   logic       wd_kick = 1'b0;
   logic [1:0] pup_code = 2'b00;
   logic [1:0] wd_code = 2'b11;
   logic       wr_commit = 1'b0;
   logic [3:0] wr_type = '0;
   logic [7:0] wr_addr = '0;
   logic [3:0] wr_nbytes = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] fdr_q;
   logic       sys_rst;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rst_supervisor #(.TICKS_PER_MS(TPM)) u0 (
      .clk(clk), .rst_n(rst_n), .lv_low(lv_low), .mr_req(mr_req), .wd_kick(wd_kick),
      .pup_code(pup_code), .wd_code(wd_code), .wr_commit(wr_commit), .wr_type(wr_type),
      .wr_addr(wr_addr), .wr_nbytes(wr_nbytes), .wr_data(wr_data),
      .fdr_q(fdr_q), .sys_rst(sys_rst));

   function automatic int rel_n(input logic [1:0] c);
      int t[4] = '{50, 200, 400, 800};
      return t[c] * TPM;
   endfunction

   function automatic int wd_n(input logic [1:0] c);
      int t[3] = '{1400, 200, 25};
      return t[c] * TPM;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic run_len(input bit val, output int n);
      n = 0;
      while (sys_rst == val && n < LIMIT) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic reg_write(input logic [3:0] t, input logic [7:0] a, input logic [3:0] nb,
                            input logic [7:0] d);
      @(negedge clk);
      wr_commit = 1'b1; wr_type = t; wr_addr = a; wr_nbytes = nb; wr_data = d;
      @(negedge clk);
      wr_commit = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      // R1 / R7: power-on delay sweep over every release code
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         rst_n = 1'b0;
         pup_code = 2'(c);
         wd_code = 2'b11;
         repeat (3) @(negedge clk);
         chk("R1 reset held during rst_n", int'(sys_rst), 1);
         chk("R7 fault register cleared", int'(fdr_q), 0);
         rst_n = 1'b1;
         @(negedge clk);
         run_len(1'b1, n);
         chk("R1 power-on delay", n, rel_n(2'(c)));
      end

      // R2 / R3 / R7 / R8: every combination of voltage and manual sources
      pup_code = 2'b00;
      for (int p = 1; p < 16; p++) begin
         reg_write(4'b1011, 8'hFF, 4'd1, 8'h00);
         lv_low = 3'(p); mr_req = p[3];
         @(negedge clk);
         chk("R2 source asserts reset", int'(sys_rst), 1);
         chk("R7 R8 flags at trigger", int'(fdr_q),
             (p[0] << 7) | (p[1] << 6) | (p[2] << 5) | (p[3] << 3));
         lv_low = 3'b111; mr_req = 1'b1;
         repeat (2) @(negedge clk);
         chk("R2 held while active", int'(sys_rst), 1);
         chk("R8 late source sets no flag", int'(fdr_q),
             (p[0] << 7) | (p[1] << 6) | (p[2] << 5) | (p[3] << 3));
         lv_low = '0; mr_req = 1'b0;
         @(negedge clk);
         run_len(1'b1, n);
         chk("R3 release delay", n, rel_n(2'b00));
      end

      // R3: a source returning during the delay restarts it
      pup_code = 2'b01;
      lv_low = 3'b010;
      @(negedge clk);
      lv_low = '0;
      repeat (150) @(negedge clk);
      lv_low = 3'b100;
      @(negedge clk);
      lv_low = '0;
      @(negedge clk);
      run_len(1'b1, n);
      chk("R3 delay restarts", n, rel_n(2'b01));
      pup_code = 2'b00;

      // R4 / R6 / R7: watchdog period from a kick, then from reset release
      for (int c = 0; c < 3; c++) begin
         reg_write(4'b1011, 8'hFF, 4'd1, 8'h00);
         wd_code = 2'(c);
         wd_kick = 1'b1;
         @(negedge clk);
         wd_kick = 1'b0;
         run_len(1'b0, n);
         chk("R4 watchdog period", n, wd_n(2'(c)));
         chk("R7 watchdog flag bit4", int'(fdr_q), 8'h10);
         run_len(1'b1, n);
         chk("R4 delay after timeout", n, rel_n(2'b00));
         run_len(1'b0, n);
         chk("R6 period restarts on release", n, wd_n(2'(c)));
         run_len(1'b1, n);
      end

      // R6: regular kicks keep reset away
      wd_code = 2'b10;
      wd_kick = 1'b1;
      @(negedge clk);
      wd_kick = 1'b0;
      n = 0;
      for (int k = 0; k < 400; k++) begin
         wd_kick = ((k % 40) == 39);
         @(negedge clk);
         if (sys_rst) n++;
      end
      wd_kick = 1'b0;
      chk("R6 kicks prevent timeout", n, 0);

      // R5: code 11 disables the watchdog
      wd_code = 2'b11;
      n = 0;
      for (int k = 0; k < 3200; k++) begin
         @(negedge clk);
         if (sys_rst) n++;
      end
      chk("R5 watchdog disabled", n, 0);

      // R9 / R10: write acceptance rules
      reg_write(4'b1011, 8'hFF, 4'd1, 8'hFF);
      chk("R10 low bits masked", int'(fdr_q), 8'hF8);
      reg_write(4'b1011, 8'hFF, 4'd1, 8'hA8);
      chk("R9 good write", int'(fdr_q), 8'hA8);
      reg_write(4'b1010, 8'hFF, 4'd1, 8'h00);
      chk("R9 wrong preamble ignored", int'(fdr_q), 8'hA8);
      reg_write(4'b1011, 8'hFE, 4'd1, 8'h00);
      chk("R9 wrong address ignored", int'(fdr_q), 8'hA8);
      reg_write(4'b1011, 8'hFF, 4'd2, 8'h00);
      chk("R9 two bytes rejected", int'(fdr_q), 8'hA8);
      reg_write(4'b1011, 8'hFF, 4'd0, 8'h00);
      chk("R9 zero bytes rejected", int'(fdr_q), 8'hA8);

      // R10: write and trigger on the same edge
      @(negedge clk);
      wr_commit = 1'b1; wr_type = 4'b1011; wr_addr = 8'hFF; wr_nbytes = 4'd1; wr_data = 8'h40;
      mr_req = 1'b1;
      @(negedge clk);
      wr_commit = 1'b0;
      chk("R10 trigger ORs onto write", int'(fdr_q), 8'h48);
      mr_req = 1'b0;
      @(negedge clk);
      run_len(1'b1, n);
      chk("R3 delay after manual reset", n, rel_n(2'b00));

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule